// File: doc/BRIEF.md
# 64-bit Compare Timer with Periodic Reload

This block is a free-running 64-bit counter with a 64-bit comparator, driven and read over a plain 32-bit register port. Software sees each 64-bit quantity as a pair of word registers. It starts the counter with a control bit and arms the comparator with another. When the count reaches or passes the compare value, a sticky pending flag is set. If the interrupt is enabled, a single-cycle interrupt pulse follows.

The block can produce periodic ticks. With auto-reload switched on, every match adds a programmed 32-bit step to the 64-bit compare value. The step is normally the input clock rate divided by the wanted tick rate.

The compare registers can only be written while the comparator is disarmed. Reads have no side effects and always return the live count. Software therefore assembles a coherent 64-bit time by reading the upper word, then the lower word, then the upper word again, and retrying whenever the two upper samples differ.

Top module: `tmr64_tick_timer`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: The count rises by exactly one per clock while control bit 0 (run) is 1, and holds while it is 0.
- R3: A write to offset 0x00 (count low word) or 0x04 (count high word) replaces only that half on the next edge, with no increment on that edge. A normal increment carries from the low word into the high word.
- R4: Reads have no side effects and return the current count, so the upper/lower/upper read with a retry on mismatch yields a coherent 64-bit value across a low-word rollover.
- R5: The control register at 0x08 holds run (bit 0), compare arm (bit 1), interrupt enable (bit 2) and auto-reload (bit 3), and reads back in those positions with upper bits zero.
- R6: A match exists while compare arm is 1 and the count is greater than or equal to the compare value (0x10 low word, 0x14 high word). It sets the pending flag (bit 0 of 0x0C) on the next edge whether or not interrupts are enabled. While compare arm is 0 no match is signalled.
- R7: Writing 0x0C with bit 0 set clears pending, and writing it with bit 0 clear has no effect. When a match and a clear fall in the same cycle, the flag stays set.
- R8: `irq_o` is a one-cycle pulse, given one clock after the first cycle of a match and only when interrupt enable is 1. A match that persists produces one pulse.
- R9: With auto-reload on, each match cycle adds the 32-bit step at 0x18 (zero-extended) to the compare value on the same edge that sets pending.
- R10: Writes to 0x10 and 0x14 are ignored while compare arm is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Byte offset of the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational from state |
| irq_o | output | 1 | One-cycle interrupt pulse per match |

## Verification
The bench drives a read sequence across a low-word rollover. A design that froze or cached the upper word would return a value off by 2^32, or would need no retry. It arms the comparator on a count that is already past the compare value. A level-style interrupt would then stay high for many cycles, and a design that ignored the arm bit would set pending while disarmed. The bench runs four auto-reload periods and checks the exact pulse cycles and the final compare value, which exposes a reload that lags by a cycle or drops the step. It also writes the compare registers while armed, and writes the status register with 0 and with 1, to catch unguarded compare updates and clear-on-any-write behaviour.

// File: rtl/tmr64_pkg.sv
package tmr64_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFF_CNT_LO = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_CNT_HI = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_STAT   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_CMP_LO = 5'h10;
    localparam logic [ADDR_W-1:0] OFF_CMP_HI = 5'h14;
    localparam logic [ADDR_W-1:0] OFF_STEP   = 5'h18;

    // Packed MSB first: run lands on bit 0, auto_rld on bit 3.
    typedef struct packed {
        logic auto_rld;
        logic irq_en;
        logic cmp_arm;
        logic run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr64_counter.sv
module tmr64_counter #(
    parameter int BW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [BW-1:0]   wdata,
    output logic [2*BW-1:0] cnt_o
);
    localparam int CW = 2 * BW;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (wr_lo) begin
            cnt_d[BW-1:0] = wdata;
        end else if (wr_hi) begin
            cnt_d[CW-1:BW] = wdata;
        end else if (run) begin
            cnt_d = cnt_q + {{(CW-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_lo && !wr_hi) |=> (cnt_q == $past(cnt_q) + 1'b1));

    a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_lo && !wr_hi) |=> $stable(cnt_q));

    a_r3_low_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (cnt_q[BW-1:0] == $past(wdata)) && (cnt_q[CW-1:BW] == $past(cnt_q[CW-1:BW])));
endmodule

// File: rtl/tmr64_compare.sv
module tmr64_compare #(
    parameter int BW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2*BW-1:0] cnt,
    input  logic            cmp_arm,
    input  logic            irq_en,
    input  logic            auto_rld,
    input  logic [BW-1:0]   step,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic            clr_pend,
    input  logic [BW-1:0]   wdata,
    output logic [2*BW-1:0] cmp_o,
    output logic            pend_o,
    output logic            irq_o
);
    localparam int CW = 2 * BW;

    typedef struct packed {
        logic [CW-1:0] cmp;
        logic          pend;
        logic          hit;
        logic          irq;
    } cmp_state_t;

    cmp_state_t s_d, s_q;
    logic       hit;
    logic [CW-1:0] step_ext;

    assign step_ext = {{(CW-BW){1'b0}}, step};

    always_comb begin
        s_d = s_q;
        hit = cmp_arm && (cnt >= s_q.cmp);
        if (!cmp_arm) begin
            if (wr_lo) s_d.cmp[BW-1:0]  = wdata;
            if (wr_hi) s_d.cmp[CW-1:BW] = wdata;
        end else if (hit && auto_rld) begin
            s_d.cmp = s_q.cmp + step_ext;
        end
        if (clr_pend) s_d.pend = 1'b0;
        if (hit)      s_d.pend = 1'b1;
        s_d.hit = hit;
        s_d.irq = hit && !s_q.hit && irq_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmp_o  = s_q.cmp;
    assign pend_o = s_q.pend;
    assign irq_o  = s_q.irq;

    a_r6_silent_when_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_arm |=> !irq_o);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    a_r8_pulse_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !irq_o);

    a_r9_reload_step: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && auto_rld) |=> (s_q.cmp == $past(s_q.cmp) + $past(step_ext)) && s_q.pend);

    a_r10_locked_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_arm && !(hit && auto_rld)) |=> $stable(s_q.cmp));
endmodule

// File: rtl/tmr64_tick_timer.sv
module tmr64_tick_timer
    import tmr64_pkg::*;
#(
    parameter int BW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BW-1:0]     bus_wdata,
    output logic [BW-1:0]     bus_rdata,
    output logic              irq_o
);
    localparam int CW = 2 * BW;

    typedef struct packed {
        ctrl_t         ctrl;
        logic [BW-1:0] step;
    } regs_t;

    regs_t regs_d, regs_q;

    logic          wr_cnt_lo, wr_cnt_hi, wr_ctrl, wr_stat;
    logic          wr_cmp_lo, wr_cmp_hi, wr_step;
    logic [CW-1:0] cnt, cmp;
    logic          pend;

    always_comb begin
        wr_cnt_lo = bus_we && (bus_addr == OFF_CNT_LO);
        wr_cnt_hi = bus_we && (bus_addr == OFF_CNT_HI);
        wr_ctrl   = bus_we && (bus_addr == OFF_CTRL);
        wr_stat   = bus_we && (bus_addr == OFF_STAT);
        wr_cmp_lo = bus_we && (bus_addr == OFF_CMP_LO);
        wr_cmp_hi = bus_we && (bus_addr == OFF_CMP_HI);
        wr_step   = bus_we && (bus_addr == OFF_STEP);
    end

    always_comb begin
        regs_d = regs_q;
        if (wr_ctrl) regs_d.ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);
        if (wr_step) regs_d.step = bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    tmr64_counter #(.BW(BW)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (regs_q.ctrl.run),
        .wr_lo (wr_cnt_lo),
        .wr_hi (wr_cnt_hi),
        .wdata (bus_wdata),
        .cnt_o (cnt)
    );

    tmr64_compare #(.BW(BW)) u_compare (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt),
        .cmp_arm  (regs_q.ctrl.cmp_arm),
        .irq_en   (regs_q.ctrl.irq_en),
        .auto_rld (regs_q.ctrl.auto_rld),
        .step     (regs_q.step),
        .wr_lo    (wr_cmp_lo),
        .wr_hi    (wr_cmp_hi),
        .clr_pend (wr_stat && bus_wdata[0]),
        .wdata    (bus_wdata),
        .cmp_o    (cmp),
        .pend_o   (pend),
        .irq_o    (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_CNT_LO: bus_rdata = cnt[BW-1:0];
            OFF_CNT_HI: bus_rdata = cnt[CW-1:BW];
            OFF_CTRL:   bus_rdata = {{(BW-CTRL_W){1'b0}}, regs_q.ctrl};
            OFF_STAT:   bus_rdata = {{(BW-1){1'b0}}, pend};
            OFF_CMP_LO: bus_rdata = cmp[BW-1:0];
            OFF_CMP_HI: bus_rdata = cmp[CW-1:BW];
            OFF_STEP:   bus_rdata = regs_q.step;
            default:    bus_rdata = '0;
        endcase
    end

    a_r8_pulse_marks_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> pend);

    a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.ctrl.cmp_arm && (cnt >= cmp)) |=> pend);
endmodule

// File: tb/tmr64_tick_timer_tb_top.sv
module tmr64_tick_timer_tb_top;
    import tmr64_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr64_tick_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drives at a falling edge; returns just after the rising edge that applied it.
    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    // Combinational read of the current state, no clock edge consumed.
    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_read(OFF_CNT_LO, v); check("R1 cnt_lo", v, 0);
        bus_read(OFF_CNT_HI, v); check("R1 cnt_hi", v, 0);
        bus_read(OFF_CTRL, v);   check("R1 ctrl", v, 0);
        bus_read(OFF_STAT, v);   check("R1 status", v, 0);
        bus_read(OFF_CMP_LO, v); check("R1 cmp_lo", v, 0);
        bus_read(OFF_CMP_HI, v); check("R1 cmp_hi", v, 0);
        bus_read(OFF_STEP, v);   check("R1 step", v, 0);
        check("R1 irq low", irq_o, 0);
    endtask

    task automatic t_ctrl_fields();
        logic [31:0] v;
        bus_write(OFF_CTRL, 32'hFFFF_FFFC); // irq_en + auto_rld, no run/arm
        bus_read(OFF_CTRL, v); check("R5 ctrl readback", v, 32'hC);
        bus_write(OFF_CTRL, 32'h0);
        bus_read(OFF_CNT_LO, v); check("R5 run clear keeps count", v, 0);
    endtask

    task automatic t_halves();
        logic [31:0] lo, hi;
        bus_write(OFF_CNT_LO, 32'hFFFF_FFFF);
        bus_write(OFF_CNT_HI, 32'h5);
        bus_read(OFF_CNT_LO, lo); bus_read(OFF_CNT_HI, hi);
        check("R3 half writes", {hi, lo}, 64'h5_FFFF_FFFF);
        bus_write(OFF_CTRL, 32'h1);          // run starts after this edge
        tick();
        bus_read(OFF_CNT_LO, lo); bus_read(OFF_CNT_HI, hi);
        check("R3 carry into high", {hi, lo}, 64'h6_0000_0000);
        bus_write(OFF_CNT_LO, 32'h100);      // no increment on write edge
        bus_read(OFF_CNT_LO, lo); bus_read(OFF_CNT_HI, hi);
        check("R3 write wins over increment", {hi, lo}, 64'h6_0000_0100);
    endtask

    task automatic t_run_hold();
        logic [31:0] a, b;
        bus_read(OFF_CNT_LO, a);
        repeat (7) tick();
        bus_read(OFF_CNT_LO, b);
        check("R2 seven steps", b - a, 7);
        bus_write(OFF_CTRL, 32'h0);
        bus_read(OFF_CNT_LO, a);
        repeat (5) tick();
        bus_read(OFF_CNT_LO, b);
        check("R2 hold when stopped", b, a);
    endtask

    task automatic t_coherent_read();
        logic [31:0] h1, lo, h2;
        int retries = 0;
        bit done = 1'b0;
        bus_write(OFF_CNT_LO, 32'hFFFF_FFFE);
        bus_write(OFF_CNT_HI, 32'h3);
        bus_write(OFF_CTRL, 32'h1);
        // Count is 3_FFFFFFFE now; one read per clock.
        while (!done) begin
            bus_read(OFF_CNT_HI, h1); tick();
            bus_read(OFF_CNT_LO, lo); tick();
            bus_read(OFF_CNT_HI, h2);
            if (h1 == h2) done = 1'b1;
            else begin retries++; tick(); end
        end
        // Low word taken four clocks after the start value.
        check("R4 coherent value", {h2, lo}, 64'h4_0000_0002);
        check("R4 one retry across rollover", retries, 1);
        bus_write(OFF_CTRL, 32'h0);
    endtask

    task automatic t_match_pending();
        logic [31:0] v;
        int pulses = 0;
        bus_write(OFF_CNT_HI, 32'h0);
        bus_write(OFF_CNT_LO, 32'd100);
        bus_write(OFF_CMP_LO, 32'd100);
        bus_write(OFF_CMP_HI, 32'h0);
        repeat (3) tick();
        bus_read(OFF_STAT, v); check("R6 no match while disarmed", v, 0);
        bus_write(OFF_CTRL, 32'h2);          // arm only
        bus_read(OFF_STAT, v); check("R6 pending not yet", v, 0);
        for (int i = 0; i < 6; i++) begin
            tick();
            if (irq_o) pulses++;
        end
        bus_read(OFF_STAT, v); check("R6 pending set", v, 1);
        check("R8 no pulse with irq disabled", pulses, 0);
        bus_write(OFF_STAT, 32'h1);          // match still present
        bus_read(OFF_STAT, v); check("R7 match beats clear", v, 1);
        bus_write(OFF_CTRL, 32'h0);
        bus_write(OFF_STAT, 32'h0);
        bus_read(OFF_STAT, v); check("R7 write 0 keeps flag", v, 1);
        bus_write(OFF_STAT, 32'h1);
        bus_read(OFF_STAT, v); check("R7 write 1 clears", v, 0);
    endtask

    task automatic t_irq_pulse();
        logic [31:0] v;
        int pulses = 0;
        int first = -1;
        bus_write(OFF_CNT_LO, 32'h0);
        bus_write(OFF_CMP_LO, 32'd10);
        bus_write(OFF_CTRL, 32'h7);          // run + arm + irq
        for (int k = 1; k <= 30; k++) begin
            tick();
            if (irq_o) begin pulses++; if (first < 0) first = k; end
        end
        check("R8 one pulse for persisting match", pulses, 1);
        check("R8 pulse one clock after match", first, 11);
        bus_read(OFF_STAT, v); check("R8 pending with pulse", v, 1);
        bus_write(OFF_CTRL, 32'h0);
        bus_write(OFF_STAT, 32'h1);
    endtask

    task automatic t_auto_reload();
        logic [31:0] v;
        int pulses = 0;
        int at[4] = '{0, 0, 0, 0};
        bus_write(OFF_CNT_LO, 32'h0);
        bus_write(OFF_CMP_LO, 32'd20);
        bus_write(OFF_STEP, 32'd10);
        bus_write(OFF_CTRL, 32'hF);
        for (int k = 1; k <= 55; k++) begin
            tick();
            if (irq_o) begin
                if (pulses < 4) at[pulses] = k;
                pulses++;
            end
        end
        check("R9 four periodic pulses", pulses, 4);
        check("R9 pulse times", {at[0][15:0], at[1][15:0], at[2][15:0], at[3][15:0]},
              {16'd21, 16'd31, 16'd41, 16'd51});
        bus_read(OFF_CMP_LO, v); check("R9 compare advanced", v, 32'd60);
    endtask

    task automatic t_cmp_lock();
        logic [31:0] v;
        bus_write(OFF_CTRL, 32'h2);          // stop, stay armed
        bus_write(OFF_CMP_LO, 32'h1234);
        bus_read(OFF_CMP_LO, v); check("R10 low write ignored", v, 32'd60);
        bus_write(OFF_CMP_HI, 32'h7);
        bus_read(OFF_CMP_HI, v); check("R10 high write ignored", v, 0);
        bus_write(OFF_CTRL, 32'h0);
        bus_write(OFF_CMP_LO, 32'h1234);
        bus_read(OFF_CMP_LO, v); check("R10 write accepted when disarmed", v, 32'h1234);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        t_reset();
        t_ctrl_fields();
        t_halves();
        t_run_hold();
        t_coherent_read();
        t_match_pending();
        t_irq_pulse();
        t_auto_reload();
        t_cmp_lock();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule